// File: doc/BRIEF.md
# Command-Driven Video Filter Configuration Bank

This block sits behind a two-wire serial slave front end. It turns received bytes into the configuration of a three-channel video filter. The front end reports framing events: a matched address with its direction bit, a STOP or abort, and each fully received data byte. The block keeps an 8-bit status word and an 8-bit cutoff code, and drives the decoded control fields to the analog side.

In a write transaction, only the first byte after the address is treated as an opcode. Most opcodes set or clear one bit of the status word. One opcode turns the next byte into a new cutoff code. Two opcodes choose which register is presented on the read-data output. A later read transaction, opened with a repeated START, ships that byte out. A soft-reset opcode restores the status word and leaves the cutoff code alone.

Top module: `cmd_cfg_bank`

## Requirements
- R1: While reset is held low and after it is released, the status word is 03h (clamps of channels 2 and 3 high, all other fields 0), the cutoff code is FFh, and rdData shows the status word.
- R2: Opcodes 02h/03h, 04h/05h and 06h/07h set the clamp of channel 1, 2 and 3 respectively to low (even code) or high (odd code). They appear on clampHigh[0], [1] and [2].
- R3: Opcode 08h selects component input and 09h selects composite. 0Ah selects internal sync and 0Bh selects external. 0Ch selects positive polarity and 0Dh selects negative. 0Eh selects filtering and 0Fh selects bypass. No other field changes.
- R4: Opcode 00h sets pwrDown. Opcode 01h clears only pwrDown and keeps every other field and the cutoff code.
- R5: Opcode 10h returns the status word to 03h and leaves the cutoff code unchanged.
- R6: After opcode 12h, the next complete byte of the same write transaction becomes the cutoff code. Any further bytes in that transaction are ignored, and so are bytes after a non-load opcode.
- R7: A load armed by 12h is dropped if a STOP or a new address arrives before the data byte. A byte that follows a new write address is an opcode again.
- R8: The status word reads as bit7 composite, bit6 external sync, bit5 negative polarity, bit4 power-down, bit3 bypass, and bits 2..0 the high clamps of channels 1..3. rdData shows the cutoff code after opcode 13h and the status word after any other opcode. The selection holds until the next opcode or a reset.
- R9: Opcodes 14h to FFh change neither register nor any output, except that they return the read selection to the status word.
- R10: A byte and a framing event in the same cycle: the byte is interpreted under the transaction phase in force before the event, and the event then sets the phase.
- R11: Bytes received with no write address pending, or after a read address, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous assert |
| addrValid | input | 1 | Pulse: own address matched (START or repeated START) |
| addrRead | input | 1 | Direction bit with addrValid, 1 = read |
| byteValid | input | 1 | Pulse: a written data byte fully received |
| byteData | input | 8 | The received byte |
| busStop | input | 1 | Pulse: STOP or transfer abort |
| pwrDown | output | 1 | Power-down request |
| filterBypass | output | 1 | Filter bypass select |
| compositeIn | output | 1 | Composite input select |
| extSyncEn | output | 1 | External sync select |
| syncNeg | output | 1 | Negative external sync polarity |
| clampHigh | output | 3 | High clamp select, bit i for channel i+1 |
| freqCode | output | 8 | Filter cutoff code |
| rdData | output | 8 | Byte to ship in the next read |

## Verification
The interesting coincidence is a completed byte arriving in the same cycle as a framing event. Two cases are driven. In the first, the cutoff data byte arrives together with STOP. In the second, an opcode arrives together with a repeated write address. The outputs are then judged against a model that applies the byte under the old phase before switching phase: the cutoff load must take effect, and the byte after the new address must act as an opcode. Every one of the 256 opcodes is also swept from varying prior states, and every cutoff code is loaded and read back.

// File: rtl/cmd_cfg_pkg.sv
package cmd_cfg_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_FREQ} phase_t;

  // strobes from the opcode decoder to the register datapath
  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic             softRst;
    logic             loadFreq;
    logic             armSel;
    logic             selFreq;
  } cmdStrobes_t;

  // status word field positions (read-back layout)
  localparam int BIT_COMPOSITE = 7;
  localparam int BIT_EXTSYNC   = 6;
  localparam int BIT_SYNCNEG   = 5;
  localparam int BIT_PWRDN     = 4;
  localparam int BIT_BYPASS    = 3;
  localparam int BIT_CLAMP1    = 2;
  localparam int BIT_CLAMP2    = 1;
  localparam int BIT_CLAMP3    = 0;

  localparam logic [REG_W-1:0] OP_SOFTRST = 8'h10;
  localparam logic [REG_W-1:0] OP_LDFREQ  = 8'h12;
  localparam logic [REG_W-1:0] OP_RDFREQ  = 8'h13;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrValid,
  input  logic             addrRead,
  input  logic             byteValid,
  input  logic [REG_W-1:0] byteData,
  input  logic             busStop,
  output cmdStrobes_t      strobes
);
  phase_t phase, phaseNxt;
  logic   inCmd, inFreq, fieldLevel;
  logic [2:0] fieldSel;

  // field addressed by an opcode pair 0..7
  function automatic int fieldBit(input logic [2:0] pairIdx);
    case (pairIdx)
      3'd0:    return BIT_PWRDN;
      3'd1:    return BIT_CLAMP1;
      3'd2:    return BIT_CLAMP2;
      3'd3:    return BIT_CLAMP3;
      3'd4:    return BIT_COMPOSITE;
      3'd5:    return BIT_EXTSYNC;
      3'd6:    return BIT_SYNCNEG;
      default: return BIT_BYPASS;
    endcase
  endfunction

  assign inCmd      = byteValid && (phase == PH_CMD);
  assign inFreq     = byteValid && (phase == PH_FREQ);
  assign fieldSel   = byteData[3:1];
  // pair 0 is inverted: even code enters power-down
  assign fieldLevel = byteData[0] ^ (fieldSel == 3'd0);

  always_comb begin
    strobes = '0;
    strobes.loadFreq = inFreq;
    if (inCmd) begin
      strobes.armSel  = 1'b1;
      strobes.selFreq = (byteData == OP_RDFREQ);
      if (byteData[REG_W-1:4] == '0) begin
        if (fieldLevel) strobes.setMask[fieldBit(fieldSel)] = 1'b1;
        else            strobes.clrMask[fieldBit(fieldSel)] = 1'b1;
      end
      strobes.softRst = (byteData == OP_SOFTRST);
    end
  end

  always_comb begin
    phaseNxt = phase;
    if (inCmd)  phaseNxt = (byteData == OP_LDFREQ) ? PH_FREQ : PH_IDLE;
    if (inFreq) phaseNxt = PH_IDLE;
    // framing events act after the byte of the same cycle
    if (busStop)   phaseNxt = PH_IDLE;
    if (addrValid) phaseNxt = addrRead ? PH_IDLE : PH_CMD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cmd_cfg_pkg::*;
#(
  parameter logic [REG_W-1:0] STATUS_RST = 8'h03,
  parameter logic [REG_W-1:0] FREQ_RST   = 8'hFF
)(
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobes_t      strobes,
  input  logic [REG_W-1:0] byteData,
  output logic [REG_W-1:0] statusWord,
  output logic [REG_W-1:0] freqCode,
  output logic [REG_W-1:0] rdData
);
  logic selFreqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusWord <= STATUS_RST;
      freqCode   <= FREQ_RST;
      selFreqQ   <= 1'b0;
    end else begin
      if (strobes.softRst) statusWord <= STATUS_RST;
      else statusWord <= (statusWord & ~strobes.clrMask) | strobes.setMask;
      if (strobes.loadFreq) freqCode <= byteData;
      if (strobes.armSel)   selFreqQ <= strobes.selFreq;
    end
  end

  assign rdData = selFreqQ ? freqCode : statusWord;
endmodule

// File: rtl/cmd_cfg_bank.sv
module cmd_cfg_bank
  import cmd_cfg_pkg::*;
#(
  parameter logic [REG_W-1:0] STATUS_RST = 8'h03,
  parameter logic [REG_W-1:0] FREQ_RST   = 8'hFF
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrValid,
  input  logic             addrRead,
  input  logic             byteValid,
  input  logic [REG_W-1:0] byteData,
  input  logic             busStop,
  output logic             pwrDown,
  output logic             filterBypass,
  output logic             compositeIn,
  output logic             extSyncEn,
  output logic             syncNeg,
  output logic [2:0]       clampHigh,
  output logic [REG_W-1:0] freqCode,
  output logic [REG_W-1:0] rdData
);
  cmdStrobes_t      strobes;
  logic [REG_W-1:0] statusWord;

  cmd_decode u_decode (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrRead(addrRead),
    .byteValid(byteValid), .byteData(byteData), .busStop(busStop),
    .strobes(strobes)
  );

  cfg_regs #(.STATUS_RST(STATUS_RST), .FREQ_RST(FREQ_RST)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .statusWord(statusWord), .freqCode(freqCode), .rdData(rdData)
  );

  assign pwrDown      = statusWord[BIT_PWRDN];
  assign filterBypass = statusWord[BIT_BYPASS];
  assign compositeIn  = statusWord[BIT_COMPOSITE];
  assign extSyncEn    = statusWord[BIT_EXTSYNC];
  assign syncNeg      = statusWord[BIT_SYNCNEG];
  assign clampHigh    = {statusWord[BIT_CLAMP3], statusWord[BIT_CLAMP2],
                         statusWord[BIT_CLAMP1]};
endmodule

// File: rtl/cmd_cfg_bank_chk.sv
module cmd_cfg_bank_chk
  import cmd_cfg_pkg::*;
#(
  parameter logic [REG_W-1:0] STATUS_RST = 8'h03
)(
  input logic             clk,
  input logic             rstN,
  input logic             byteValid,
  input logic [REG_W-1:0] byteData,
  input cmdStrobes_t      strobes,
  input logic [REG_W-1:0] statusWord,
  input logic [REG_W-1:0] freqCode,
  input logic [REG_W-1:0] rdData
);
  // R6
  freq_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadFreq |=> freqCode == $past(byteData));
  // R5
  soft_rst_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.softRst |=> statusWord == STATUS_RST);
  // R5
  soft_rst_freq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.softRst |=> $stable(freqCode));
  // R11
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusWord) |-> $past(byteValid));
  // R11
  freq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqCode) |-> $past(byteValid));
  // R2
  one_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.setMask | strobes.clrMask));
  // R8
  read_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.armSel && strobes.selFreq) |=> rdData == freqCode);
  // R6
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadFreq && strobes.armSel));
endmodule

bind cmd_cfg_bank cmd_cfg_bank_chk #(.STATUS_RST(STATUS_RST)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
  .strobes(strobes), .statusWord(statusWord), .freqCode(freqCode),
  .rdData(rdData)
);

// File: tb/test_cmd_cfg_bank.sv
module test_cmd_cfg_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrValid = 1'b0, addrRead = 1'b0, byteValid = 1'b0, busStop = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic pwrDown, filterBypass, compositeIn, extSyncEn, syncNeg;
  logic [2:0] clampHigh;
  logic [7:0] freqCode, rdData;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] expStatus, expFreq;
  logic expSel;
  bit done = 0;

  always #10 clk = ~clk;

  cmd_cfg_bank i_cmd_cfg_bank (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrRead(addrRead),
    .byteValid(byteValid), .byteData(byteData), .busStop(busStop),
    .pwrDown(pwrDown), .filterBypass(filterBypass), .compositeIn(compositeIn),
    .extSyncEn(extSyncEn), .syncNeg(syncNeg), .clampHigh(clampHigh),
    .freqCode(freqCode), .rdData(rdData)
  );

  function automatic logic [7:0] statusPorts();
    return {compositeIn, extSyncEn, syncNeg, pwrDown, filterBypass,
            clampHigh[0], clampHigh[1], clampHigh[2]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk({tag, " status"}, statusPorts(), expStatus);
    chk({tag, " freq"}, freqCode, expFreq);
    chk({tag, " rdData"}, rdData, expSel ? expFreq : expStatus);
  endtask

  // model of one opcode, from the requirement text
  task automatic modelCmd(input logic [7:0] c);
    int pos[8] = '{4, 2, 1, 0, 7, 6, 5, 3};
    int pair;
    expSel = (c == 8'h13);
    if (c < 8'h10) begin
      pair = int'(c) / 2;
      expStatus[pos[pair]] = (pair == 0) ? (c % 2 == 0) : (c % 2 == 1);
    end else if (c == 8'h10) begin
      expStatus = 8'h03;
    end
  endtask

  // all tasks start and end at a negedge
  task automatic pulse(input logic a, input logic rd, input logic b,
                       input logic [7:0] d, input logic s);
    addrValid = a; addrRead = rd; byteValid = b; byteData = d; busStop = s;
    @(negedge clk);
    addrValid = 0; addrRead = 0; byteValid = 0; byteData = 8'h00; busStop = 0;
  endtask

  task automatic wrCmd(input logic [7:0] c);
    pulse(1, 0, 0, 8'h00, 0);
    pulse(0, 0, 1, c, 0);
    pulse(0, 0, 0, 8'h00, 1);
    modelCmd(c);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    string tag;
    expStatus = 8'h03; expFreq = 8'hFF; expSel = 0;
    repeat (3) @(negedge clk);
    chkAll("R1 during reset");
    rstN = 1;
    @(negedge clk);
    chkAll("R1 after reset");

    // opcode sweep from varying prior states
    for (int c = 0; c < 256; c++) begin
      wrCmd(8'((c * 5 + 3) % 16));
      wrCmd(8'(c));
      if (c <= 1) tag = "R4";
      else if (c <= 7) tag = "R2";
      else if (c <= 15) tag = "R3";
      else if (c == 16) tag = "R5";
      else if (c == 17 || c == 19) tag = "R8";
      else if (c == 18) tag = "R7";
      else tag = "R9";
      chkAll($sformatf("%s op=%02h", tag, c));
      pulse(1, 1, 0, 8'h00, 0);
      chk($sformatf("R8 readback op=%02h", c), rdData, expSel ? expFreq : expStatus);
      pulse(0, 0, 0, 8'h00, 1);
    end

    // cutoff load and read back for every code
    for (int v = 0; v < 256; v++) begin
      pulse(1, 0, 0, 8'h00, 0);
      pulse(0, 0, 1, 8'h12, 0);
      pulse(0, 0, 1, 8'(v), 0);
      pulse(0, 0, 0, 8'h00, 1);
      expFreq = 8'(v); expSel = 0;
      chk("R6 load", freqCode, expFreq);
      pulse(1, 0, 0, 8'h00, 0);
      pulse(0, 0, 1, 8'h13, 0);
      pulse(1, 1, 0, 8'h00, 0);
      expSel = 1;
      chk("R8 freq read", rdData, expFreq);
      pulse(0, 0, 0, 8'h00, 1);
    end

    // R5: soft reset keeps cutoff
    wrCmd(8'h09); wrCmd(8'h00);
    pulse(1, 0, 0, 8'h00, 0); pulse(0, 0, 1, 8'h12, 0);
    pulse(0, 0, 1, 8'h33, 0); pulse(0, 0, 0, 8'h00, 1);
    expFreq = 8'h33;
    wrCmd(8'h10);
    chkAll("R5 soft reset");

    // R6: extra bytes after an opcode are ignored
    pulse(1, 0, 0, 8'h00, 0);
    pulse(0, 0, 1, 8'h09, 0); pulse(0, 0, 1, 8'h0F, 0); pulse(0, 0, 1, 8'h00, 0);
    pulse(0, 0, 0, 8'h00, 1);
    modelCmd(8'h09);
    chkAll("R6 trailing bytes");

    // R7: STOP before data byte
    pulse(1, 0, 0, 8'h00, 0); pulse(0, 0, 1, 8'h12, 0); pulse(0, 0, 0, 8'h00, 1);
    pulse(0, 0, 1, 8'hA5, 0);
    expSel = 0;
    chkAll("R7 stop abort");
    // R7: repeated write address before data byte, next byte is an opcode
    pulse(1, 0, 0, 8'h00, 0); pulse(0, 0, 1, 8'h12, 0);
    pulse(1, 0, 0, 8'h00, 0); pulse(0, 0, 1, 8'h0F, 0); pulse(0, 0, 0, 8'h00, 1);
    modelCmd(8'h0F);
    chkAll("R7 restart abort");

    // R11: bytes with no address, or after a read address
    pulse(0, 0, 1, 8'h00, 0);
    chkAll("R11 no address");
    pulse(1, 1, 0, 8'h00, 0); pulse(0, 0, 1, 8'h12, 0); pulse(0, 0, 1, 8'h01, 0);
    pulse(0, 0, 0, 8'h00, 1);
    chkAll("R11 after read address");

    // R10: data byte together with STOP still loads
    pulse(1, 0, 0, 8'h00, 0); pulse(0, 0, 1, 8'h12, 0);
    pulse(0, 0, 1, 8'h5A, 1);
    expFreq = 8'h5A;
    chkAll("R10 byte with stop");
    // R10: opcode together with a repeated write address, then another opcode
    pulse(1, 0, 0, 8'h00, 0);
    pulse(1, 0, 1, 8'h0B, 0);
    modelCmd(8'h0B);
    chkAll("R10 byte with address");
    pulse(0, 0, 1, 8'h0D, 0); pulse(0, 0, 0, 8'h00, 1);
    modelCmd(8'h0D);
    chkAll("R10 next transaction");

    // R8: selection persists until the next opcode
    wrCmd(8'h13);
    repeat (4) @(negedge clk);
    chk("R8 persist", rdData, expFreq);
    wrCmd(8'h01);
    chk("R8 disarm", rdData, expStatus);
    chkAll("R4 wake keeps fields");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule